// File: doc/BRIEF.md
# Index-register memory transfer sequencer

This block carries out the four instructions of an 8-bit, sixteen-register machine that work relative to its 12-bit index register I. A single start pulse delivers the lower twelve bits of an instruction. The register number X sits in bits 11:8 and the sub-operation code sits in bits 7:0. The block then does one of four things:

- Adds VX to I.
- Splits VX into three decimal digits and stores them at I onward.
- Saves V0 through VX to memory from I upward.
- Restores V0 through VX from memory from I upward.

The block talks to its surroundings through these ports:

- A read port into the register file.
- A write port into the register file.
- A write strobe for I. The current value of I comes in on a plain input.
- A byte-wide memory port. A read returns its data in the following cycle.

It makes at most one memory access per cycle, with no idle cycles inside a burst. It raises `done_o` in the cycle that finishes the operation. While the block is busy, further start pulses have no effect. A sub-operation code it does not know produces an `illegal_o` pulse and no access at all.

Top module: `idx_xfer_seq`

## Requirements
- R1: During reset and after it, `busy_o`, `done_o`, `illegal_o`, `mem_req_o`, `rf_wr_en_o` and `idx_we_o` are low. The cycle after any `done_o`, `busy_o` is low again.
- R2: Sub-op 0x1E: in the cycle after the start edge, `idx_we_o` is high with `idx_wdata_o` = (I + VX) mod 4096, `done_o` is high, and there is no memory access.
- R3: Sub-op 0x33: in cycles 1, 2 and 3 after the start edge, the block writes the hundreds, tens and ones digit of VX (values 0..9, zero-extended) to I, I+1 and I+2. `done_o` is high in cycle 3.
- R4: Sub-op 0x55: in cycle k+1 after the start edge (k = 0..X), the block writes Vk to address I+k. `rf_rd_addr_o` equals k in that cycle. `done_o` is high on the beat with k = X.
- R5: Sub-op 0x65: in cycle k+1 (k = 0..X), the block issues a read of address I+k. In cycle k+2 it writes register Vk with the byte returned. `done_o` is high together with the write of VX.
- R6: `idx_we_o` stays low during sub-ops 0x33, 0x55 and 0x65, so I keeps its value.
- R7: Any other sub-op value: in the cycle after the start edge, `illegal_o` and `done_o` are high. No memory access, register write or index write happens.
- R8: A start pulse while `busy_o` is high is ignored, whatever instruction comes with it.
- R9: X is taken from `instr_i[11:8]` and the sub-op from `instr_i[7:0]`, both sampled at the start edge. VX is read through `rf_rd_addr_o`, which presents `instr_i[11:8]` while the block is idle.
- R10: Memory addresses wrap modulo 4096, and consecutive beats of one operation use consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, taken only while idle |
| instr_i | input | 12 | Register number in 11:8, sub-op code in 7:0 |
| idx_i | input | 12 | Current value of the index register I |
| idx_we_o | output | 1 | Index register write strobe |
| idx_wdata_o | output | 12 | New index value |
| rf_rd_addr_o | output | 4 | Register file read address |
| rf_rd_data_i | input | 8 | Register file read data, combinational |
| rf_wr_en_o | output | 1 | Register file write enable |
| rf_wr_addr_o | output | 4 | Register file write address |
| rf_wr_data_o | output | 8 | Register file write data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 12 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after a read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last cycle of an operation |
| illegal_o | output | 1 | Unknown sub-op code seen |

## Verification
During a restore burst, the memory read for register k+1 and the register-file write of register k occur in the same cycle. The two meet only when X is at least 1.

The bench provokes this overlap with restores of X = 0, X = 15 and random X, some of them starting near address 0xFFF. Each cycle it compares the read address and the write address and data against a bench memory pattern that changes for every operation. A write landing one cycle early or late, or carrying the wrong byte, shows up as a mismatch.

A checker also requires every register write to follow a read request in the previous cycle.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

  localparam logic [7:0] SUB_ADD_IDX = 8'h1E;
  localparam logic [7:0] SUB_DEC_PUT = 8'h33;
  localparam logic [7:0] SUB_SAVE    = 8'h55;
  localparam logic [7:0] SUB_REST    = 8'h65;

  typedef enum logic [2:0] {
    K_ADD_IDX,
    K_DEC_PUT,
    K_SAVE,
    K_REST,
    K_BAD
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADD_IDX,
    S_DEC_PUT,
    S_SAVE,
    S_REST,
    S_DRAIN,
    S_BAD
  } state_e;

endpackage

// File: rtl/ixs_rst_sync.sv
module ixs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/ixs_decode.sv
module ixs_decode
  import ixs_pkg::*;
(
  input  logic [7:0] sub_i,
  output kind_e      kind_o
);

  always_comb begin
    unique case (sub_i)
      SUB_ADD_IDX: kind_o = K_ADD_IDX;
      SUB_DEC_PUT: kind_o = K_DEC_PUT;
      SUB_SAVE:    kind_o = K_SAVE;
      SUB_REST:    kind_o = K_REST;
      default:     kind_o = K_BAD;
    endcase
  end

endmodule

// File: rtl/ixs_bcd.sv
// Shift-and-add-3 binary to decimal split, purely combinational.
module ixs_bcd #(
  parameter int DATA_W = 8,
  parameter int DIGITS = 3
) (
  input  logic [DATA_W-1:0]   val_i,
  output logic [4*DIGITS-1:0] digits_o
);

  localparam int SC_W = DATA_W + 4 * DIGITS;

  logic [SC_W-1:0] sc;

  always_comb begin
    sc = '0;
    sc[DATA_W-1:0] = val_i;
    for (int i = 0; i < DATA_W; i++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (sc[DATA_W + 4*d +: 4] >= 4'd5) begin
          sc[DATA_W + 4*d +: 4] = sc[DATA_W + 4*d +: 4] + 4'd3;
        end
      end
      sc = sc << 1;
    end
    digits_o = sc[DATA_W +: 4*DIGITS];
  end

endmodule

// File: rtl/ixs_seq.sv
module ixs_seq
  import ixs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int REG_W  = 4,
  parameter int DIGITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  kind_e               kind_i,
  input  logic [REG_W-1:0]    x_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [4*DIGITS-1:0] digits_i,
  input  logic [DATA_W-1:0]   rf_rd_data_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [DATA_W-1:0]   vx_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                illegal_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [REG_W-1:0]    rf_rd_addr_o,
  output logic                rf_wr_en_o,
  output logic [REG_W-1:0]    rf_wr_addr_o,
  output logic [DATA_W-1:0]   rf_wr_data_o,
  output logic                idx_we_o,
  output logic [ADDR_W-1:0]   idx_wdata_o
);

  localparam logic [REG_W-1:0] DIG_LAST = REG_W'(DIGITS - 1);

  state_e            state_q, state_d;
  logic [REG_W-1:0]  cnt_q, cnt_d;
  logic [REG_W-1:0]  last_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] vx_q;
  logic              pend_q, pend_d;
  logic [REG_W-1:0]  pend_addr_q, pend_addr_d;
  logic              cap_en;
  logic              at_last;
  logic              dig_last;
  logic [3:0]        dig_sel;

  assign cap_en   = (state_q == S_IDLE) && start_i;
  assign at_last  = (cnt_q == last_q);
  assign dig_last = (cnt_q == DIG_LAST);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    pend_d      = 1'b0;
    pend_addr_d = cnt_q;
    unique case (state_q)
      S_IDLE: begin
        cnt_d = '0;
        if (start_i) begin
          unique case (kind_i)
            K_ADD_IDX: state_d = S_ADD_IDX;
            K_DEC_PUT: state_d = S_DEC_PUT;
            K_SAVE:    state_d = S_SAVE;
            K_REST:    state_d = S_REST;
            default:   state_d = S_BAD;
          endcase
        end
      end
      S_ADD_IDX: state_d = S_IDLE;
      S_BAD:     state_d = S_IDLE;
      S_DEC_PUT: begin
        if (dig_last) state_d = S_IDLE;
        else          cnt_d   = cnt_q + 1'b1;
      end
      S_SAVE: begin
        if (at_last) state_d = S_IDLE;
        else         cnt_d   = cnt_q + 1'b1;
      end
      S_REST: begin
        pend_d = 1'b1;
        if (at_last) state_d = S_DRAIN;
        else         cnt_d   = cnt_q + 1'b1;
      end
      S_DRAIN:   state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  // sequencing registers, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      pend_q      <= pend_d;
      pend_addr_q <= pend_addr_d;
    end
  end

  // operand capture, enabled on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      base_q <= '0;
      vx_q   <= '0;
    end else if (cap_en) begin
      last_q <= x_i;
      base_q <= base_i;
      vx_q   <= rf_rd_data_i;
    end
  end

  // output decode
  always_comb begin
    dig_sel = digits_i[4*(DIGITS-1-int'(cnt_q)) +: 4];
  end

  assign vx_o         = vx_q;
  assign busy_o       = (state_q != S_IDLE);
  assign illegal_o    = (state_q == S_BAD);
  assign done_o       = (state_q == S_ADD_IDX) || (state_q == S_BAD) ||
                        ((state_q == S_DEC_PUT) && dig_last) ||
                        ((state_q == S_SAVE) && at_last) ||
                        (state_q == S_DRAIN);
  assign mem_req_o    = (state_q == S_DEC_PUT) || (state_q == S_SAVE) ||
                        (state_q == S_REST);
  assign mem_we_o     = (state_q == S_DEC_PUT) || (state_q == S_SAVE);
  assign mem_addr_o   = base_q + {{(ADDR_W-REG_W){1'b0}}, cnt_q};
  assign mem_wdata_o  = (state_q == S_DEC_PUT) ? {{(DATA_W-4){1'b0}}, dig_sel}
                                               : rf_rd_data_i;
  assign rf_rd_addr_o = (state_q == S_IDLE) ? x_i : cnt_q;
  assign rf_wr_en_o   = pend_q;
  assign rf_wr_addr_o = pend_addr_q;
  assign rf_wr_data_o = mem_rdata_i;
  assign idx_we_o     = (state_q == S_ADD_IDX);
  assign idx_wdata_o  = base_q + {{(ADDR_W-DATA_W){1'b0}}, vx_q};

endmodule

// File: rtl/idx_xfer_seq.sv
module idx_xfer_seq
  import ixs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int NREG   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [$clog2(NREG)+7:0]   instr_i,
  input  logic [ADDR_W-1:0]         idx_i,
  output logic                      idx_we_o,
  output logic [ADDR_W-1:0]         idx_wdata_o,
  output logic [$clog2(NREG)-1:0]   rf_rd_addr_o,
  input  logic [DATA_W-1:0]         rf_rd_data_i,
  output logic                      rf_wr_en_o,
  output logic [$clog2(NREG)-1:0]   rf_wr_addr_o,
  output logic [DATA_W-1:0]         rf_wr_data_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_wdata_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      illegal_o
);

  localparam int REG_W  = $clog2(NREG);
  localparam int DIGITS = (DATA_W * 30103) / 100000 + 1;

  logic                rst_sync_n;
  kind_e               kind;
  logic [DATA_W-1:0]   vx_val;
  logic [4*DIGITS-1:0] digits;

  ixs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ixs_decode u_dec (
    .sub_i  (instr_i[7:0]),
    .kind_o (kind)
  );

  ixs_bcd #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_bcd (
    .val_i    (vx_val),
    .digits_o (digits)
  );

  ixs_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W),
    .DIGITS (DIGITS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start_i),
    .kind_i       (kind),
    .x_i          (instr_i[REG_W+7:8]),
    .base_i       (idx_i),
    .digits_i     (digits),
    .rf_rd_data_i (rf_rd_data_i),
    .mem_rdata_i  (mem_rdata_i),
    .vx_o         (vx_val),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .illegal_o    (illegal_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .rf_rd_addr_o (rf_rd_addr_o),
    .rf_wr_en_o   (rf_wr_en_o),
    .rf_wr_addr_o (rf_wr_addr_o),
    .rf_wr_data_o (rf_wr_data_o),
    .idx_we_o     (idx_we_o),
    .idx_wdata_o  (idx_wdata_o)
  );

endmodule

// File: rtl/idx_xfer_seq_chk.sv
module idx_xfer_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rf_wr_en_o,
  input logic              idx_we_o
);

  a_r1_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r2_idx_write_alone: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we_o |-> (done_o && !mem_req_o && !rf_wr_en_o));

  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en_o |-> $past(mem_req_o && !mem_we_o));

  a_r6_idx_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we_o |-> !$past(busy_o));

  a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (done_o && !mem_req_o && !rf_wr_en_o && !idx_we_o));

  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && $past(mem_req_o && !done_o)) |->
      (mem_addr_o == $past(mem_addr_o) + 1'b1));

endmodule

bind idx_xfer_seq idx_xfer_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .illegal_o  (illegal_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .rf_wr_en_o (rf_wr_en_o),
  .idx_we_o   (idx_we_o)
);

// File: tb/idx_xfer_seq_tb_top.sv
module idx_xfer_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [11:0] instr;
  logic [11:0] idx_r;
  logic        idx_we;
  logic [11:0] idx_wdata;
  logic [3:0]  rf_rd_addr;
  logic [7:0]  rf_rd_data;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_addr;
  logic [7:0]  rf_wr_data;
  logic        mem_req;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  rdata_q;
  logic        busy;
  logic        done;
  logic        illegal;

  logic [7:0]  regs [16];
  logic [7:0]  salt;
  int          total = 0;
  int          bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_xfer_seq dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .instr_i      (instr),
    .idx_i        (idx_r),
    .idx_we_o     (idx_we),
    .idx_wdata_o  (idx_wdata),
    .rf_rd_addr_o (rf_rd_addr),
    .rf_rd_data_i (rf_rd_data),
    .rf_wr_en_o   (rf_wr_en),
    .rf_wr_addr_o (rf_wr_addr),
    .rf_wr_data_o (rf_wr_data),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (rdata_q),
    .busy_o       (busy),
    .done_o       (done),
    .illegal_o    (illegal)
  );

  assign rf_rd_data = regs[rf_rd_addr];

  function automatic logic [7:0] pat(logic [11:0] a, logic [7:0] s);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ s;
  endfunction

  function automatic logic [7:0] dec_digit(logic [7:0] v, int pos);
    int r;
    if (pos == 0)      r = int'(v) / 100;
    else if (pos == 1) r = (int'(v) / 10) % 10;
    else               r = int'(v) % 10;
    return 8'(r);
  endfunction

  // environment models: register file, index register, memory read path
  always @(posedge clk) begin
    if (rf_wr_en) regs[rf_wr_addr] <= rf_wr_data;
    if (idx_we)   idx_r <= idx_wdata;
    if (mem_req && !mem_we) rdata_q <= pat(mem_addr, salt);
  end

  task automatic check(bit ok, string tag, logic [50:0] got, logic [50:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [50:0] pack_obs();
    return {busy, done, illegal, mem_req, mem_we, mem_addr, mem_wdata,
            rf_wr_en, rf_wr_addr, rf_wr_data, idx_we, idx_wdata};
  endfunction

  // kind: 0 add-index, 1 decimal put, 2 save, 3 restore, 4 unknown
  function automatic int kind_of(logic [7:0] sub);
    case (sub)
      8'h1E:   return 0;
      8'h33:   return 1;
      8'h55:   return 2;
      8'h65:   return 3;
      default: return 4;
    endcase
  endfunction

  task automatic run_op(logic [11:0] ins, logic [11:0] base, bit spam);
    int          x;
    int          kind;
    int          n;
    logic [7:0]  v;
    string       tag;
    x     = int'(ins[11:8]);
    kind  = kind_of(ins[7:0]);
    idx_r = base;
    salt  = 8'($urandom);
    v     = regs[x];
    case (kind)
      0:       begin n = 1;     tag = "R2"; end
      1:       begin n = 3;     tag = "R3/R6"; end
      2:       begin n = x + 1; tag = "R4/R6"; end
      3:       begin n = x + 2; tag = "R5/R6"; end
      default: begin n = 1;     tag = "R7"; end
    endcase
    tag = {tag, "/R9"};
    if (int'(base) + n > 12'hFFF) tag = {tag, "/R10"};
    if (spam) tag = {tag, "/R8"};
    start = 1'b1;
    instr = ins;
    @(negedge clk);
    for (int k = 1; k <= n + 1; k++) begin
      bit          ok;
      bit          e_busy, e_done, e_ill, e_req, e_we, e_rfwe, e_idxwe;
      logic [11:0] e_addr, e_idxdata;
      logic [7:0]  e_wdata, e_rfdata;
      logic [3:0]  e_rfaddr;
      e_busy = (k <= n);
      e_done = (k == n);
      e_ill = 0; e_req = 0; e_we = 0; e_rfwe = 0; e_idxwe = 0;
      e_addr = '0; e_idxdata = '0; e_wdata = '0; e_rfdata = '0; e_rfaddr = '0;
      if (k <= n) begin
        case (kind)
          0: begin e_idxwe = 1; e_idxdata = base + {4'h0, v}; end
          1: begin
            e_req = 1; e_we = 1; e_addr = base + 12'(k - 1);
            e_wdata = dec_digit(v, k - 1);
          end
          2: begin
            e_req = 1; e_we = 1; e_addr = base + 12'(k - 1);
            e_wdata = regs[k - 1];
          end
          3: begin
            if (k <= x + 1) begin e_req = 1; e_addr = base + 12'(k - 1); end
            if (k >= 2) begin
              e_rfwe = 1; e_rfaddr = 4'(k - 2);
              e_rfdata = pat(base + 12'(k - 2), salt);
            end
          end
          default: e_ill = 1;
        endcase
      end
      ok = (busy == e_busy) && (done == e_done) && (illegal == e_ill) &&
           (mem_req == e_req) && (rf_wr_en == e_rfwe) && (idx_we == e_idxwe);
      if (e_req)   ok = ok && (mem_we == e_we) && (mem_addr == e_addr) &&
                        (!e_we || mem_wdata == e_wdata);
      if (kind == 2 && k <= n) ok = ok && (rf_rd_addr == 4'(k - 1));
      if (e_rfwe)  ok = ok && (rf_wr_addr == e_rfaddr) && (rf_wr_data == e_rfdata);
      if (e_idxwe) ok = ok && (idx_wdata == e_idxdata);
      check(ok, (k == n + 1) ? {tag, "/R1 idle"} : tag, pack_obs(),
            {e_busy, e_done, e_ill, e_req, e_we, e_addr, e_wdata,
             e_rfwe, e_rfaddr, e_rfdata, e_idxwe, e_idxdata});
      if (spam && k < n) instr = 12'h000;
      else               start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) regs[i] = 8'($urandom);
    idx_r = '0; salt = '0; rdata_q = '0;
    start = 1'b0; instr = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!(busy | done | illegal | mem_req | rf_wr_en | idx_we), "R1 in reset",
          pack_obs(), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!(busy | done | illegal | mem_req | rf_wr_en | idx_we), "R1 after reset",
          pack_obs(), '0);

    // directed corners
    regs[3] = 8'd0;   run_op(12'h333, 12'h100, 0);   // R3 zero value
    regs[4] = 8'd255; run_op(12'h433, 12'hFFE, 0);   // R3 max value, R10 wrap
    regs[5] = 8'd100; run_op(12'h533, 12'h040, 1);   // R3 with start held
    regs[2] = 8'hFF;  run_op(12'h21E, 12'hFFF, 0);   // R2 wrap
    run_op(12'h055, 12'h200, 0);                     // R4 single byte
    run_op(12'hF55, 12'hFF8, 1);                     // R4 full burst, wrap, R8
    run_op(12'h065, 12'h300, 0);                     // R5 single byte
    run_op(12'hF65, 12'hFFA, 1);                     // R5 full burst, wrap, R8
    run_op(12'h700, 12'h123, 0);                     // R7
    run_op(12'h9FF, 12'h123, 0);                     // R7
    run_op(12'h11F, 12'h123, 0);                     // R7 near-miss code

    // constrained random
    for (int t = 0; t < 80; t++) begin
      int          sel;
      logic [7:0]  sub;
      logic [11:0] base;
      sel = int'($urandom % 5);
      case (sel)
        0: sub = 8'h1E;
        1: sub = 8'h33;
        2: sub = 8'h55;
        3: sub = 8'h65;
        default: begin
          sub = 8'($urandom);
          if (kind_of(sub) != 4) sub = 8'h00;
        end
      endcase
      base = 12'($urandom);
      if ($urandom % 4 == 0) base = 12'hFF0 | 12'($urandom % 16);
      run_op({4'($urandom), sub}, base, ($urandom % 3) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule